// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a small field-configurable logic device inside a larger design. Twelve input pins and eight bidirectional lines feed an AND plane. Each product term ANDs any chosen mix of true and inverted literals of twenty signals: the twelve input pins plus one feedback signal from each of the eight output cells. Each output cell owns eight product terms. The cell ORs them, or ORs seven of them and uses the first term as its own output enable. It then presents the result through a flip-flop or straight through, with a selectable polarity.

The configuration enters on a serial stream. A load FSM has three states. `LD_IDLE` waits. `LD_ROWS` shifts in 64 rows of 40 fuse bits and writes each row when its 40th bit arrives. `LD_CTRL` shifts in an 18-bit control word and applies it on the last bit. The transitions are: `LD_IDLE`→`LD_ROWS` on `cfg_start`; `LD_ROWS`→`LD_CTRL` after the last bit of row 63; `LD_CTRL`→`LD_IDLE` after the 18th control bit. From any state, `cfg_start` restarts the load in `LD_ROWS` at row 0, bit 0.

Each cell has a kind (`CK_OFF`, `CK_COMB_ALL`, `CK_COMB_GATED`, `CK_REG`). The kind is decoded from the two-bit global mode and the cell's select bit. In registered mode, pin 0 acts as the common clock, seen as a rising edge between successive samples. Pin 11 acts as an active-low output enable for the registered cells. Both pins still feed the AND plane. A preload port writes all cell registers directly for test.

Top module: `sop_logic_array`

## Requirements
- R1: While `rst_n` is low, and after its release before any load, every `io_oe` bit is 0, `cfg_busy` is 0, and every cell register holds 0.
- R2: A load is bits sent on `cfg_valid` cycles, LSB first. Row 0 comes first and row 63 last, 40 bits each. The 18-bit control word follows: bits 7:0 are polarity, bits 15:8 are cell select, and bits 17:16 are the global mode. `cfg_busy` is 1 from the cycle after `cfg_start` until the final control bit. While it is 1, all `io_oe` bits are 0.
- R3: Row r belongs to cell r/8, term r%8. Column 2k is the true literal of signal k and column 2k+1 is its complement. Signals 0..11 are `in_pins`, and signal 12+c is the feedback of cell c. A fuse bit of 1 keeps the literal in the term. A row with all bits 1 gives 0. A row with all bits 0 gives 1.
- R4: Simple mode (00): a selected cell drives the OR of its 8 terms with `io_oe`=1. An unselected cell has `io_oe`=0.
- R5: Complex mode (01): a selected cell drives the OR of terms 1..7, and term 0 is its `io_oe`. An unselected cell has `io_oe`=0.
- R6: Registered mode (10), selected cell: on a clock edge where `in_pins[0]` is 1 and was 0 at the previous edge, the register loads the OR of all 8 terms. At all other edges it holds. `io_oe` is the inverse of `in_pins[11]`.
- R7: Registered mode, unselected cell: it behaves as a complex-mode selected cell.
- R8: Polarity bit 1 drives the sum (or register) true. Polarity bit 0 drives its inverse.
- R9: The feedback of a registered cell is its register. The feedback of any other cell is its `io_in`.
- R10: `preload_en` loads `preload_val` into all cell registers at the next edge, in any mode. It takes priority over a clock-pin edge.
- R11: Outside registered mode, the cell registers hold whatever the clock pin does.
- R12: Mode 11 behaves exactly as simple mode.
- R13: `cfg_start` during a load abandons it and restarts at row 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cfg_start | input | 1 | Begins or restarts a configuration load |
| cfg_valid | input | 1 | Qualifies `cfg_bit` |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_busy | output | 1 | Load in progress |
| in_pins | input | 12 | Dedicated inputs; bit 0 is clock/input, bit 11 is enable/input |
| preload_en | input | 1 | Direct register load strobe |
| preload_val | input | 8 | Value for direct register load |
| io_in | input | 8 | Level seen on each bidirectional line |
| io_out | output | 8 | Value driven on each line |
| io_oe | output | 8 | Drive enable of each line |

## Verification
The sweeps cover two fuse corners: a fully intact row and a fully blown row. A design that got the literal sense backwards would turn the first from 0 to 1. In registered mode the bench holds the clock pin high across a second edge while changing data. A level-sensitive clock would reload the register and break the following check. A preload issued on the same edge as a clock-pin rise must win. The register contents must survive a detour through simple mode while the clock pin toggles. A load abandoned partway by a second start must leave no shifted bits behind; a misaligned image would scramble every later sweep.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        GM_SIMPLE     = 2'b00,
        GM_COMPLEX    = 2'b01,
        GM_REGISTERED = 2'b10,
        GM_SIMPLE_ALT = 2'b11
    } glob_mode_e;

    typedef enum logic [1:0] {
        LD_IDLE = 2'b00,
        LD_ROWS = 2'b01,
        LD_CTRL = 2'b10
    } ld_state_e;

    typedef enum logic [1:0] {
        CK_OFF        = 2'b00,
        CK_COMB_ALL   = 2'b01,
        CK_COMB_GATED = 2'b10,
        CK_REG        = 2'b11
    } cell_kind_e;

endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader
    import sop_pkg::*;
#(
    parameter int NUM_ROWS  = 64,
    parameter int NUM_COLS  = 40,
    parameter int NUM_CELLS = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_start,
    input  logic                               cfg_valid,
    input  logic                               cfg_bit,
    output logic [NUM_ROWS-1:0][NUM_COLS-1:0]  fuse_q,
    output logic [NUM_CELLS-1:0]               pol_q,
    output logic [NUM_CELLS-1:0]               sel_q,
    output glob_mode_e                         mode_q,
    output logic                               busy
);

    localparam int CTRL_BITS = 2 * NUM_CELLS + 2;
    localparam int CNT_MAX   = (NUM_COLS > CTRL_BITS) ? NUM_COLS : CTRL_BITS;
    localparam int CW        = $clog2(CNT_MAX);
    localparam int RW        = $clog2(NUM_ROWS);

    ld_state_e              state_q, state_d;
    logic [CW-1:0]          bit_cnt_q;
    logic [RW-1:0]          row_q;
    logic [NUM_COLS-1:0]    row_sh_q;
    logic [CTRL_BITS-1:0]   ctl_sh_q;
    logic                   row_done, ctl_done, last_row;
    logic [NUM_COLS-1:0]    row_word;
    logic [CTRL_BITS-1:0]   ctl_word;

    assign row_done = (state_q == LD_ROWS) && cfg_valid && (bit_cnt_q == CW'(NUM_COLS - 1));
    assign ctl_done = (state_q == LD_CTRL) && cfg_valid && (bit_cnt_q == CW'(CTRL_BITS - 1));
    assign last_row = (row_q == RW'(NUM_ROWS - 1));
    assign row_word = {cfg_bit, row_sh_q[NUM_COLS-1:1]};
    assign ctl_word = {cfg_bit, ctl_sh_q[CTRL_BITS-1:1]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_start) begin
            state_d = LD_ROWS;
        end else begin
            unique case (state_q)
                LD_IDLE: state_d = LD_IDLE;
                LD_ROWS: if (row_done && last_row) state_d = LD_CTRL;
                LD_CTRL: if (ctl_done) state_d = LD_IDLE;
                default: state_d = LD_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // counters and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            row_q     <= '0;
            row_sh_q  <= '0;
            ctl_sh_q  <= '0;
        end else if (cfg_start) begin
            bit_cnt_q <= '0;
            row_q     <= '0;
        end else if (cfg_valid && (state_q != LD_IDLE)) begin
            if (row_done || ctl_done) bit_cnt_q <= '0;
            else                      bit_cnt_q <= bit_cnt_q + 1'b1;
            if (row_done) row_q <= row_q + 1'b1;
            if (state_q == LD_ROWS) row_sh_q <= row_word;
            if (state_q == LD_CTRL) ctl_sh_q <= ctl_word;
        end
    end

    // fuse storage and control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fuse_q <= '1;
            pol_q  <= '0;
            sel_q  <= '0;
            mode_q <= GM_SIMPLE;
        end else begin
            if (row_done) fuse_q[row_q] <= row_word;
            if (ctl_done) begin
                pol_q  <= ctl_word[NUM_CELLS-1:0];
                sel_q  <= ctl_word[2*NUM_CELLS-1:NUM_CELLS];
                mode_q <= glob_mode_e'(ctl_word[CTRL_BITS-1:2*NUM_CELLS]);
            end
        end
    end

    // output process
    always_comb begin
        busy = (state_q != LD_IDLE);
    end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int NUM_SIG  = 20,
    parameter int NUM_ROWS = 64
) (
    input  logic [NUM_SIG-1:0]                  sig,
    input  logic [NUM_ROWS-1:0][2*NUM_SIG-1:0]  fuse,
    output logic [NUM_ROWS-1:0]                 term
);

    localparam int NUM_COLS = 2 * NUM_SIG;

    logic [NUM_COLS-1:0] lit;

    // even column: true literal, odd column: complement
    for (genvar k = 0; k < NUM_SIG; k++) begin : g_lit
        assign lit[2*k]   = sig[k];
        assign lit[2*k+1] = ~sig[k];
    end

    // an intact fuse (1) includes the literal; a blown one forces a 1 into the AND
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign term[r] = &(~fuse[r] | lit);
    end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int TERMS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TERMS-1:0]  terms,
    input  glob_mode_e        mode,
    input  logic              sel,
    input  logic              pol,
    input  logic              clk_rise,
    input  logic              oe_pin,
    input  logic              busy,
    input  logic              preload_en,
    input  logic              preload_bit,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb,
    output logic              q
);

    cell_kind_e kind;
    logic       sum_all, sum_tail, val, oe_raw;

    assign sum_all  = |terms;
    assign sum_tail = |terms[TERMS-1:1];

    // kind decode from the global mode and the local select
    always_comb begin
        unique case (mode)
            GM_REGISTERED: kind = sel ? CK_REG        : CK_COMB_GATED;
            GM_COMPLEX:    kind = sel ? CK_COMB_GATED : CK_OFF;
            default:       kind = sel ? CK_COMB_ALL   : CK_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= 1'b0;
        else if (preload_en)                  q <= preload_bit;
        else if ((kind == CK_REG) && clk_rise) q <= sum_all;
    end

    always_comb begin
        unique case (kind)
            CK_REG: begin
                val    = pol ? q : ~q;
                oe_raw = ~oe_pin;
                fb     = q;
            end
            CK_COMB_ALL: begin
                val    = pol ? sum_all : ~sum_all;
                oe_raw = 1'b1;
                fb     = pad_in;
            end
            CK_COMB_GATED: begin
                val    = pol ? sum_tail : ~sum_tail;
                oe_raw = terms[0];
                fb     = pad_in;
            end
            default: begin
                val    = 1'b0;
                oe_raw = 1'b0;
                fb     = pad_in;
            end
        endcase
        pad_out = val;
        pad_oe  = oe_raw & ~busy;
    end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
    import sop_pkg::*;
#(
    parameter int NUM_IN    = 12,
    parameter int NUM_CELLS = 8,
    parameter int TERMS     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_start,
    input  logic                  cfg_valid,
    input  logic                  cfg_bit,
    output logic                  cfg_busy,
    input  logic [NUM_IN-1:0]     in_pins,
    input  logic                  preload_en,
    input  logic [NUM_CELLS-1:0]  preload_val,
    input  logic [NUM_CELLS-1:0]  io_in,
    output logic [NUM_CELLS-1:0]  io_out,
    output logic [NUM_CELLS-1:0]  io_oe
);

    localparam int NUM_SIG  = NUM_IN + NUM_CELLS;
    localparam int NUM_COLS = 2 * NUM_SIG;
    localparam int NUM_ROWS = NUM_CELLS * TERMS;
    localparam int CLK_PIN  = 0;
    localparam int OE_PIN   = NUM_IN - 1;

    logic [NUM_ROWS-1:0][NUM_COLS-1:0] fuse;
    logic [NUM_CELLS-1:0]              cell_pol, cell_sel, fb, reg_q;
    glob_mode_e                        glob_mode;
    logic                              clk_pin_q, clk_rise;
    logic [NUM_SIG-1:0]                sig;
    logic [NUM_ROWS-1:0]               terms;

    sop_cfg_loader #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS),
        .NUM_CELLS(NUM_CELLS)
    ) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_start(cfg_start),
        .cfg_valid(cfg_valid),
        .cfg_bit  (cfg_bit),
        .fuse_q   (fuse),
        .pol_q    (cell_pol),
        .sel_q    (cell_sel),
        .mode_q   (glob_mode),
        .busy     (cfg_busy)
    );

    // clock pin sampled; a 0-to-1 step between samples is a register clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_pin_q <= 1'b0;
        else        clk_pin_q <= in_pins[CLK_PIN];
    end
    assign clk_rise = in_pins[CLK_PIN] & ~clk_pin_q;

    assign sig = {fb, in_pins};

    sop_and_plane #(
        .NUM_SIG (NUM_SIG),
        .NUM_ROWS(NUM_ROWS)
    ) u_plane (
        .sig (sig),
        .fuse(fuse),
        .term(terms)
    );

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        sop_macrocell #(
            .TERMS(TERMS)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .terms      (terms[g*TERMS +: TERMS]),
            .mode       (glob_mode),
            .sel        (cell_sel[g]),
            .pol        (cell_pol[g]),
            .clk_rise   (clk_rise),
            .oe_pin     (in_pins[OE_PIN]),
            .busy       (cfg_busy),
            .preload_en (preload_en),
            .preload_bit(preload_val[g]),
            .pad_in     (io_in[g]),
            .pad_out    (io_out[g]),
            .pad_oe     (io_oe[g]),
            .fb         (fb[g]),
            .q          (reg_q[g])
        );
    end

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk
    import sop_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_start,
    input logic                  cfg_busy,
    input logic                  preload_en,
    input logic [NUM_CELLS-1:0]  preload_val,
    input logic [NUM_CELLS-1:0]  io_oe,
    input logic [NUM_CELLS-1:0]  reg_q,
    input logic [NUM_CELLS-1:0]  cell_sel,
    input logic                  clk_rise,
    input glob_mode_e            glob_mode
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0));

    assert_no_drive_loading_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> (io_oe == '0));

    assert_unselected_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_mode != GM_REGISTERED) |-> ((io_oe & ~cell_sel) == '0));

    assert_preload_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (reg_q == $past(preload_val)));

    assert_reg_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !(clk_rise && (glob_mode == GM_REGISTERED))) |=> $stable(reg_q));

    assert_load_needs_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_busy) |-> $past(cfg_start));

endmodule

bind sop_logic_array sop_logic_array_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .cfg_busy   (cfg_busy),
    .preload_en (preload_en),
    .preload_val(preload_val),
    .io_oe      (io_oe),
    .reg_q      (reg_q),
    .cell_sel   (cell_sel),
    .clk_rise   (clk_rise),
    .glob_mode  (glob_mode)
);

// File: tb/tb_sop_logic_array.sv
module tb_sop_logic_array;

    localparam int NR = 64;
    localparam int NCOL = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, cfg_start, cfg_valid, cfg_bit, cfg_busy, preload_en;
    logic [11:0] pins_d;
    logic [7:0]  preload_val, ext_d, io_in, io_out, io_oe;

    assign io_in = (io_oe & io_out) | (~io_oe & ext_d);

    sop_logic_array dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_valid(cfg_valid),
        .cfg_bit(cfg_bit), .cfg_busy(cfg_busy), .in_pins(pins_d),
        .preload_en(preload_en), .preload_val(preload_val),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    logic [NCOL-1:0] tf [NR];
    logic [7:0]      t_pol, t_sel, q_m;
    logic [1:0]      t_mode;
    logic [31:0]     rs = 32'h1ACE5;
    int              n_chk = 0, n_fail = 0;

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference behaviour computed from the requirements
    task automatic model(input logic [11:0] p, input logic [7:0] x,
                         output logic [7:0] o, output logic [7:0] e, output logic [7:0] d);
        logic [19:0] s;
        logic [63:0] t;
        logic        regm;
        regm = (t_mode == 2'b10);
        s[11:0] = p;
        for (int c = 0; c < 8; c++) s[12+c] = (regm && t_sel[c]) ? q_m[c] : x[c];
        for (int r = 0; r < NR; r++) begin
            t[r] = 1'b1;
            for (int k = 0; k < 20; k++) begin
                if (tf[r][2*k]   && !s[k]) t[r] = 1'b0;
                if (tf[r][2*k+1] &&  s[k]) t[r] = 1'b0;
            end
        end
        for (int c = 0; c < 8; c++) begin
            logic [7:0] tc;
            logic       all, tail;
            tc   = t[c*8 +: 8];
            all  = |tc;
            tail = |tc[7:1];
            d[c] = all;
            if (regm && t_sel[c]) begin
                o[c] = t_pol[c] ? q_m[c] : ~q_m[c];
                e[c] = ~p[11];
            end else if ((regm && !t_sel[c]) || (t_mode == 2'b01 && t_sel[c])) begin
                o[c] = t_pol[c] ? tail : ~tail;
                e[c] = tc[0];
            end else if (t_mode != 2'b01 && !regm && t_sel[c]) begin
                o[c] = t_pol[c] ? all : ~all;
                e[c] = 1'b1;
            end else begin
                o[c] = 1'b0;
                e[c] = 1'b0;
            end
        end
    endtask

    task automatic check_now(input string req);
        logic [7:0] o, e, d;
        model(pins_d, ext_d, o, e, d);
        check(req, {io_oe, io_out & e}, {e, o & e});
    endtask

    task automatic gen_fuses(input logic [19:0] mask);
        for (int r = 0; r < NR; r++) begin
            int n;
            tf[r] = '0;
            n = 1 + int'(rnd() % 32'd3);
            for (int j = 0; j < n; j++) begin
                int          k;
                logic [31:0] v;
                k = int'(rnd() % 32'd20);
                for (int tr = 0; tr < 64 && !mask[k]; tr++) k = int'(rnd() % 32'd20);
                if (!mask[k]) k = 1;
                v = rnd();
                tf[r][2*k + int'(v[0])] = 1'b1;
            end
        end
    endtask

    task automatic send_bit(input logic b);
        cfg_valid = 1'b1;
        cfg_bit   = b;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic load_cfg(input bit restart_first);
        logic [17:0] word;
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        if (restart_first) begin
            // R13: abandon a partial load
            for (int i = 0; i < 100; i++) begin
                logic [31:0] v;
                v = rnd();
                send_bit(v[3]);
            end
            cfg_start = 1'b1;
            @(negedge clk);
            cfg_start = 1'b0;
        end
        for (int r = 0; r < NR; r++) begin
            for (int b = 0; b < NCOL; b++) begin
                if (r == 32 && b == 0)
                    check("R2 busy", {7'b0, cfg_busy, io_oe}, {7'b0, 1'b1, 8'h00});
                send_bit(tf[r][b]);
            end
        end
        word = {t_mode, t_sel, t_pol};
        for (int b = 0; b < 18; b++) send_bit(word[b]);
        check("R2 done", {15'b0, cfg_busy}, 16'h0000);
    endtask

    task automatic sweep(input string req, input int n, input bit exh);
        for (int i = 0; i < n; i++) begin
            logic [31:0] v;
            v = rnd();
            @(negedge clk);
            pins_d = exh ? 12'(i) : v[11:0];
            ext_d  = v[19:12];
            #1 check_now(req);
        end
    endtask

    task automatic reg_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] v;
            logic [7:0]  o, e, d;
            v = rnd();
            @(negedge clk);
            pins_d = v[11:0] & 12'hFFE;
            ext_d  = v[19:12];
            #1 check_now("R6 R8");
            @(negedge clk);
            pins_d[0] = 1'b1;
            #1 model(pins_d, ext_d, o, e, d);
            check_now("R7");
            @(negedge clk);
            q_m = (q_m & ~t_sel) | (d & t_sel);
            v = rnd();
            pins_d[10:1] = v[9:0];
            #1 check_now("R6 load");
            @(negedge clk);
            #1 check_now("R6 R9 hold");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] sel_keep;
        rst_n = 1'b0; cfg_start = 1'b0; cfg_valid = 1'b0; cfg_bit = 1'b0;
        preload_en = 1'b0; preload_val = '0; pins_d = '0; ext_d = '0; q_m = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {7'b0, cfg_busy, io_oe}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1", {7'b0, cfg_busy, io_oe}, 16'h0000);

        // R3: all intact rows give 0, an all-blown row gives 1
        for (int r = 0; r < NR; r++) tf[r] = '1;
        t_mode = 2'b00; t_sel = 8'hFF; t_pol = 8'h0F;
        load_cfg(0);
        sweep("R3 intact", 16, 0);
        tf[24] = '0;
        load_cfg(0);
        sweep("R3 blown", 16, 0);

        // simple mode, then the alternate code, then complex
        t_mode = 2'b00; t_sel = 8'b1101_0111; t_pol = 8'b0110_1001;
        gen_fuses({~t_sel, 12'hFFF});
        load_cfg(0);
        sweep("R4 R8 R9", 4096, 1);
        t_mode = 2'b11;
        load_cfg(0);
        sweep("R12", 1024, 0);
        t_mode = 2'b01;
        load_cfg(0);
        sweep("R5 R8", 4096, 1);

        // registered mode, loaded after an abandoned start
        t_mode = 2'b10; t_sel = 8'b1011_0101; t_pol = 8'b1100_0110;
        gen_fuses({t_sel, 12'h7FE});
        pins_d = '0;
        load_cfg(1);
        @(negedge clk);
        #1 check_now("R1 R11 R13");
        reg_run(150);

        // R10: preload wins over a simultaneous clock-pin rise
        @(negedge clk);
        pins_d[0] = 1'b0; pins_d[11] = 1'b0;
        @(negedge clk);
        preload_en = 1'b1; preload_val = 8'h5A; pins_d[0] = 1'b1;
        @(negedge clk);
        preload_en = 1'b0; q_m = 8'h5A;
        #1 check_now("R10");

        // R11: registers hold through simple mode while the clock pin toggles
        sel_keep = t_sel;
        t_mode = 2'b00; t_sel = 8'h00;
        load_cfg(0);
        #1 check_now("R4 off");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pins_d[0] = ~pins_d[0];
        end
        t_mode = 2'b10; t_sel = sel_keep;
        @(negedge clk);
        pins_d[0] = 1'b0;
        load_cfg(0);
        pins_d[11] = 1'b0;
        #1 check_now("R11");
        reg_run(20);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule